// File: doc/BRIEF.md
# Signed-Amount Shift and Rotate Unit

A purely combinational 16-bit shifter that sits in a processor ALU. It takes an operand, a 5-bit two's-complement shift amount taken straight from an instruction immediate, and a 2-bit operation select. It produces a shifted or rotated result together with zero and negative flags. Carry and overflow are not generated.

The direction of travel is not a separate control. It comes from the sign of the amount. A non-negative amount moves bits toward the LSB by 0 to 15 places. A negative amount moves bits toward the MSB by its magnitude, which is 1 to 16. All three operations share a single right-moving barrel network. Left moves reuse that network: the operand is bit-reversed before the network and the result is reversed again after it.

Top module: `sa_shift_unit`

## Requirements
- R1: With op_i = 0 (arithmetic) and a non-negative amount n, result_o equals operand_i moved toward the LSB by n places, with vacated upper bits copied from operand_i[15].
- R2: With op_i = 1 (logical) and a non-negative amount n, result_o equals operand_i moved toward the LSB by n places, with vacated upper bits zero.
- R3: With op_i = 2 (rotate) and a non-negative amount n, result_o equals operand_i rotated toward the LSB by n places, so bits leaving bit 0 re-enter at bit 15.
- R4: With a negative amount (amount_i[4] = 1), each operation moves toward the MSB by the magnitude. Arithmetic and logical fill vacated low bits with zero, and rotate wraps bits from bit 15 back into bit 0.
- R5: With amount_i = 5'b10000 (-16), arithmetic and logical give 0x0000, and rotate returns operand_i unchanged.
- R6: With amount_i = 0, ops 0 to 2 return operand_i unchanged.
- R7: op_i = 3 is reserved and forces result_o to 0x0000 for any operand and amount.
- R8: zero_o is 1 exactly when result_o is 0x0000.
- R9: neg_o equals result_o[15].
- R10: All outputs follow the inputs combinationally, in the same cycle, with no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Value to shift or rotate |
| amount_i | input | 5 | Signed shift amount (two's complement) |
| op_i | input | 2 | 0 arithmetic, 1 logical, 2 rotate, 3 reserved |
| result_o | output | 16 | Shifted or rotated value |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result bit 15 |

## Verification
Every output is due in the same cycle as its stimulus, because no register lies on any path. The bench applies each vector just after a falling clock edge. It samples 1 ns later, well before the next rising edge, so the sample never races an edge. For the exhaustive sweep, which covers every operation against every amount from -16 to 15, the expected values come from a bit-indexed reference model kept in the bench.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int DATA_W = 16;
  localparam int AMT_W  = 5;

  typedef enum logic [1:0] {
    OP_ARITH = 2'd0,
    OP_LOGIC = 2'd1,
    OP_ROT   = 2'd2,
    OP_RSVD  = 2'd3
  } sa_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } sa_fill_e;

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) bit_rev[i] = v[DATA_W-1-i];
  endfunction
endpackage

// File: rtl/sa_amount_dec.sv
module sa_amount_dec #(
  parameter int AMT_W = 5
) (
  input  logic [AMT_W-1:0] amount_i,
  output logic             left_o,
  output logic [AMT_W-1:0] mag_o
);
  // magnitude of the most negative code wraps to 2^(AMT_W-1), still fits unsigned
  assign left_o = amount_i[AMT_W-1];
  assign mag_o  = left_o ? (~amount_i + 1'b1) : amount_i;
endmodule

// File: rtl/sa_barrel_right.sv
module sa_barrel_right
  import sa_pkg::*;
#(
  parameter int W     = 16,
  parameter int MAG_W = 5
) (
  input  logic [W-1:0]     data_i,
  input  logic [MAG_W-1:0] mag_i,
  input  sa_fill_e         fill_i,
  output logic [W-1:0]     data_o
);
  logic [MAG_W:0][W-1:0] stg;
  logic                  fill_bit;

  assign fill_bit = (fill_i == FILL_SIGN) ? data_i[W-1] : 1'b0;
  assign stg[0]   = data_i;

  for (genvar k = 0; k < MAG_W; k++) begin : g_stage
    localparam int STEP   = 1 << k;
    localparam int ROT_SH = STEP % W;
    localparam int SHF_SH = (STEP > W) ? W : STEP;
    logic [2*W-1:0] wide;
    assign wide = (fill_i == FILL_WRAP) ? ({stg[k], stg[k]} >> ROT_SH)
                                        : ({{W{fill_bit}}, stg[k]} >> SHF_SH);
    assign stg[k+1] = mag_i[k] ? wide[W-1:0] : stg[k];
  end

  assign data_o = stg[MAG_W];
endmodule

// File: rtl/sa_flags.sv
module sa_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] result_i,
  output logic         zero_o,
  output logic         neg_o
);
  assign zero_o = (result_i == '0);
  assign neg_o  = result_i[W-1];
endmodule

// File: rtl/sa_shift_unit.sv
module sa_shift_unit
  import sa_pkg::*;
(
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              neg_o
);
  sa_op_e            op;
  logic              left;
  logic [AMT_W-1:0]  mag;
  logic [DATA_W-1:0] net_in, net_out, shaped;
  sa_fill_e          fill;

  assign op = sa_op_e'(op_i);

  sa_amount_dec #(.AMT_W(AMT_W)) u_dec (
    .amount_i(amount_i), .left_o(left), .mag_o(mag)
  );

  // left moves: reverse, shift right, reverse back; arithmetic-left fills zero
  always_comb begin
    unique case (op)
      OP_ROT:   fill = FILL_WRAP;
      OP_ARITH: fill = left ? FILL_ZERO : FILL_SIGN;
      default:  fill = FILL_ZERO;
    endcase
  end

  assign net_in = left ? bit_rev(operand_i) : operand_i;

  sa_barrel_right #(.W(DATA_W), .MAG_W(AMT_W)) u_barrel (
    .data_i(net_in), .mag_i(mag), .fill_i(fill), .data_o(net_out)
  );

  assign shaped   = left ? bit_rev(net_out) : net_out;
  assign result_o = (op == OP_RSVD) ? '0 : shaped;

  sa_flags #(.W(DATA_W)) u_flags (
    .result_i(result_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  always_comb begin
    if (op != OP_RSVD && amount_i == '0)
      assert_zero_amt_identity_R6: assert (result_o == operand_i);
    if (op == OP_ROT)
      assert_rot_keeps_ones_R3: assert ($countones(result_o) == $countones(operand_i));
    if (op == OP_ARITH && !amount_i[AMT_W-1])
      assert_arith_keeps_sign_R1: assert (result_o[DATA_W-1] == operand_i[DATA_W-1]);
    if (op == OP_LOGIC && !amount_i[AMT_W-1] && amount_i != '0)
      assert_logic_clears_msb_R2: assert (!result_o[DATA_W-1]);
    if (op != OP_ROT && amount_i[AMT_W-1])
      assert_left_clears_lsb_R4: assert (!result_o[0]);
    if (op == OP_RSVD)
      assert_rsvd_zero_R7: assert (result_o == '0 && zero_o && !neg_o);
    assert_zero_flag_R8: assert (zero_o == ($countones(result_o) == 0));
  end
endmodule

// File: tb/tb_sa_shift_unit.sv
module tb_sa_shift_unit;
  logic        clk = 1'b0;
  logic [15:0] operand = '0;
  logic [4:0]  amount = '0;
  logic [1:0]  op = '0;
  logic [15:0] result;
  logic        zero, neg;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  sa_shift_unit dut (
    .operand_i(operand), .amount_i(amount), .op_i(op),
    .result_o(result), .zero_o(zero), .neg_o(neg)
  );

  // {op, amount, operand, expected}
  typedef struct packed { logic [1:0] op; logic [4:0] amt; logic [15:0] opnd; logic [15:0] exp; } vec_t;
  localparam vec_t VECS [10] = '{
    '{2'd0, 5'd4,     16'h8000, 16'hF800},
    '{2'd1, 5'd4,     16'h8000, 16'h0800},
    '{2'd2, 5'd1,     16'h0001, 16'h8000},
    '{2'd0, 5'b11111, 16'h0001, 16'h0002},
    '{2'd1, 5'b10000, 16'hFFFF, 16'h0000},
    '{2'd2, 5'b10000, 16'h1234, 16'h1234},
    '{2'd2, 5'b11100, 16'h1234, 16'h2341},
    '{2'd0, 5'd15,    16'h7FFF, 16'h0000},
    '{2'd0, 5'd15,    16'hFFFF, 16'hFFFF},
    '{2'd3, 5'd3,     16'hFFFF, 16'h0000}
  };

  function automatic logic [15:0] ref_model(input logic [1:0] o, input int a, input logic [15:0] v);
    logic [15:0] r;
    if (o == 2'd3) return 16'h0;
    for (int i = 0; i < 16; i++) begin
      int s = i + a;
      if (o == 2'd2) r[i] = v[((s % 16) + 16) % 16];
      else if (s >= 0 && s < 16) r[i] = v[s];
      else if (s >= 16 && o == 2'd0) r[i] = v[15];
      else r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s result op=%0d amt=%0d opnd=%h: got %h exp %h", req, op, $signed(amount), operand, result, exp);
    end
    checks++;
    if (zero !== (exp == 16'h0) || neg !== exp[15]) begin
      failures++;
      $display("FAIL R8/R9 flags for %h: got z=%b n=%b exp z=%b n=%b", exp, zero, neg, exp == 16'h0, exp[15]);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [4:0] a, input logic [15:0] v);
    @(negedge clk);
    op = o; amount = a; operand = v;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] pool [6];
    // R10: idle inputs give settled outputs with no state
    apply(2'd0, 5'd0, 16'h0);
    check("R10 idle", 16'h0000);

    foreach (VECS[i]) begin
      apply(VECS[i].op, VECS[i].amt, VECS[i].opnd);
      check($sformatf("R1-vector%0d (R4 R5 R7)", i), VECS[i].exp);
    end

    pool[0] = 16'h8000; pool[1] = 16'hFFFF; pool[2] = 16'h0001;
    pool[3] = 16'h0000; pool[4] = 16'($urandom); pool[5] = 16'($urandom);
    for (int o = 0; o < 4; o++) begin
      for (int a = -16; a < 16; a++) begin
        for (int p = 0; p < 6; p++) begin
          string tag;
          apply(2'(o), 5'(a), pool[p]);
          if (o == 3) tag = "R7";
          else if (a == -16) tag = "R5";
          else if (a == 0) tag = "R6";
          else if (a < 0) tag = "R4";
          else tag = (o == 0) ? "R1" : (o == 1) ? "R2" : "R3";
          check(tag, ref_model(2'(o), a, pool[p]));
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule